// File: doc/BRIEF.md
# SMBus Target Front End with Programmable Address

This block is the bus-facing half of a two-wire (SMBus/I2C-style) target device. It runs on a fast system clock and oversamples the clock and data lines. It finds START, repeated START and STOP conditions on those lines. It shifts address and data bytes in most significant bit first, and it answers each received byte by pulling data low for the whole ninth clock. The data line is open drain, so the block only produces an enable that pulls the line low.

A write transaction has three parts: an address byte with the direction bit low, a command byte that becomes the register pointer, and any number of data bytes. Each data byte is passed to a register file as a one-cycle write strobe, and the pointer then advances by one. A read transaction usually follows a command write and a repeated START. The block takes bytes from the register file's combinational read port at the current pointer, shifts them out, and samples the master's acknowledge. An acknowledge asks for the next byte, and a not-acknowledge ends the read.

The device address is set by a register value from outside the block. If that value is zero, or is one of the two reserved codes, the block uses a pin-strap selection instead. The command byte is refused while the device is rebooting, while it is writing to flash, or when the register file reports that the command is an illegal location.

Top module: `smb_target`

## Requirements
- R1: After reset the data-line pull-down (`sda_oe`) and the write strobe (`rf_wr`) are both low.
- R2: When `addr_reg` is nonzero and is neither 7'h09 nor 7'h7F, only that 7-bit value is acknowledged as the device address. A change to it applies from the next address byte.
- R3: When `addr_reg` is 7'h00, 7'h09 or 7'h7F, the device address is `STRAP_BASE + strap_sel`. `strap_sel` encodes 0 = ground, 1 = supply, 2 = tied to clock line, 3 = tied to data line.
- R4: An address byte whose upper seven bits do not match gets no acknowledge. All following clocks are ignored until the next START: no acknowledge and no write strobe.
- R5: A matching address byte, an accepted command byte and every write data byte are acknowledged by holding data low through the whole ninth clock.
- R6: A command byte received while `reboot_busy`, `flash_busy` or `cmd_illegal` is high is not acknowledged. The transaction is then ignored until the next START.
- R7: Write data byte k (counting from 0) after command C produces exactly one `rf_wr` pulse, with `rf_wdata` set to the byte and `rf_addr` equal to C+k (mod 256).
- R8: In a read (address byte bit 0 = 1), read byte k is `rf_rdata` taken at pointer C+k, sent MSB first. Data is released during each ninth clock. A master acknowledge continues the read and a not-acknowledge ends it.
- R9: A STOP (data rising while clock high) at any bit position returns the block to idle. Later clocks without a START produce no acknowledge and no write.
- R10: A STOP in the same clock-high interval as the START before it is ignored, and the address phase goes on.
- R11: A repeated START restarts address reception without a STOP, and the pointer set by the earlier command is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_oe | output | 1 | High pulls the data line low |
| addr_reg | input | 7 | Programmable device address, 0 selects the pin strap |
| strap_sel | input | 2 | Pin-strap setting: 0 ground, 1 supply, 2 clock line, 3 data line |
| reboot_busy | input | 1 | Device rebooting, refuse command |
| flash_busy | input | 1 | Flash write in progress, refuse command |
| cmd_illegal | input | 1 | Received command addresses an illegal location |
| rf_addr | output | 8 | Register-file pointer |
| rf_wr | output | 1 | One-cycle write strobe |
| rf_wdata | output | 8 | Write data qualified by rf_wr |
| rf_rdata | input | 8 | Register-file read data at rf_addr (combinational) |

## Verification
The hardest situation to reach is a bus condition at an unusual point: a STOP partway through a byte, or a STOP inside the same clock-high interval as a START. Ordinary master behaviour never produces either. The bench has line-level master primitives that it can interleave freely. It creates an illegal START-then-STOP inside one clock-high interval and expects the following address to be acknowledged. It also cuts address and write bytes short with a STOP and then clocks a full byte without a START, which must produce neither an acknowledge nor a write. Random transactions mix addresses taken from the register, addresses taken from the strap, the reserved codes, wrong addresses and each refusal input.

// File: rtl/smb_target.sv
module smb_target #(
  parameter logic [6:0] STRAP_BASE = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [6:0] addr_reg,
  input  logic [1:0] strap_sel,
  input  logic       reboot_busy,
  input  logic       flash_busy,
  input  logic       cmd_illegal,
  output logic [7:0] rf_addr,
  output logic       rf_wr,
  output logic [7:0] rf_wdata,
  input  logic [7:0] rf_rdata
);

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_CMD, P_WR, P_RD} phase_t;

  phase_t     ph;
  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [3:0] bitcnt;
  logic [7:0] rx, tx;
  logic       rw, mack, start_hi;

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise      = scl_s & ~scl_d;
  wire fall      = ~scl_s & scl_d;
  wire reg_ok    = (addr_reg != 7'h00) && (addr_reg != 7'h09) && (addr_reg != 7'h7F);
  wire [6:0] eff_addr = reg_ok ? addr_reg : STRAP_BASE + {5'b0, strap_sel};
  wire cmd_block = reboot_busy | flash_busy | cmd_illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= P_IDLE;
      bitcnt   <= '0;
      rx       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      start_hi <= 1'b0;
      sda_oe   <= 1'b0;
      rf_addr  <= '0;
      rf_wr    <= 1'b0;
      rf_wdata <= '0;
    end else begin
      rf_wr <= 1'b0;
      if (fall) start_hi <= 1'b0;
      if (start_det) begin
        ph       <= P_ADDR;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        start_hi <= 1'b1;
      end else if (stop_det && !start_hi) begin
        ph     <= P_IDLE;
        sda_oe <= 1'b0;
      end else if (ph != P_IDLE) begin
        if (rise) begin
          if (bitcnt < 4'd8) rx <= {rx[6:0], sda_s};
          else               mack <= ~sda_s;
          bitcnt <= bitcnt + 4'd1;
        end
        if (fall) begin
          if (bitcnt == 4'd8) begin
            case (ph)
              P_ADDR: if (rx[7:1] == eff_addr) begin
                        sda_oe <= 1'b1;
                        rw     <= rx[0];
                      end else ph <= P_IDLE;
              P_CMD:  if (!cmd_block) begin
                        sda_oe  <= 1'b1;
                        rf_addr <= rx;
                      end else ph <= P_IDLE;
              P_WR:   begin
                        sda_oe   <= 1'b1;
                        rf_wr    <= 1'b1;
                        rf_wdata <= rx;
                      end
              P_RD:   begin
                        sda_oe  <= 1'b0;
                        rf_addr <= rf_addr + 8'd1;
                      end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (ph)
              P_ADDR: if (rw) begin
                        ph     <= P_RD;
                        tx     <= rf_rdata;
                        sda_oe <= ~rf_rdata[7];
                      end else ph <= P_CMD;
              P_CMD:  ph <= P_WR;
              P_WR:   rf_addr <= rf_addr + 8'd1;
              P_RD:   if (mack) begin
                        tx     <= rf_rdata;
                        sda_oe <= ~rf_rdata[7];
                      end else ph <= P_IDLE;
              default: ;
            endcase
          end else if (ph == P_RD) begin
            sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_IDLE) |-> !sda_oe);  // R4
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt == 4'd9 && (ph == P_ADDR || ph == P_CMD || ph == P_WR)) |-> sda_oe);  // R5
  AST_READ_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt == 4'd9 && ph == P_RD) |-> !sda_oe);  // R8
  AST_WR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> $past(ph == P_WR));  // R7
  AST_CMD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bitcnt == 4'd8 && ph == P_CMD && cmd_block) |=> (!sda_oe && ph == P_IDLE));  // R6
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_hi) |=> ph == P_IDLE);  // R9
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (ph == P_ADDR && bitcnt == 4'd0 && !sda_oe));  // R11

endmodule

// File: tb/smb_target_test.sv
module smb_target_test;
  localparam int T = 8;
  localparam logic [6:0] BASE = 7'h50;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] addr_reg = 7'h00;
  logic [1:0] strap_sel = 2'd0;
  logic       reboot_busy = 1'b0, flash_busy = 1'b0, cmd_illegal = 1'b0;
  logic       sda_oe, rf_wr;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  wire        sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [7:0] rd_model(input logic [7:0] a);
    logic [7:0] m;
    m = a * 8'd29;
    return m ^ 8'hA5;
  endfunction

  function automatic logic [6:0] exp_addr(input logic [6:0] r, input logic [1:0] s);
    if (r != 7'h00 && r != 7'h09 && r != 7'h7F) return r;
    return BASE + {5'b0, s};
  endfunction

  assign rf_rdata = rd_model(rf_addr);

  smb_target #(.STRAP_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .addr_reg(addr_reg), .strap_sel(strap_sel), .reboot_busy(reboot_busy),
    .flash_busy(flash_busy), .cmd_illegal(cmd_illegal), .rf_addr(rf_addr),
    .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata));

  int         wr_n = 0;
  logic [7:0] wr_a [64];
  logic [7:0] wr_d [64];
  always @(posedge clk)
    if (rf_wr) begin
      wr_a[wr_n % 64] <= rf_addr;
      wr_d[wr_n % 64] <= rf_wdata;
      wr_n <= wr_n + 1;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (T) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; hp(); m_scl = 1'b1; hp(); m_sda = 1'b0; hp(); m_scl = 1'b0; hp();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_sda = 1'b1; hp();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, output logic whole);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; hp(); a1 = sda_line;
    m_scl = 1'b1; hp(); a2 = sda_line;
    m_scl = 1'b0;
    acked = !a2;
    whole = !a1 && !a2;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d, output logic released);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); m_scl = 1'b1; hp(); d[i] = sda_line; m_scl = 1'b0;
    end
    hp(); released = !sda_oe; m_sda = !mack;
    hp(); m_scl = 1'b1; hp(); released = released && !sda_oe;
    m_scl = 1'b0; m_sda = 1'b1;
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] cmd, input int n, input string req);
    logic ack, whole;
    int base;
    logic [7:0] d [4];
    base = wr_n;
    do_start();
    send_byte({a, 1'b0}, ack, whole);
    chk(whole, {req, " R5 address ack"}, whole, 1);
    send_byte(cmd, ack, whole);
    chk(whole, "R5 command ack", whole, 1);
    for (int k = 0; k < n; k++) begin
      d[k] = 8'($urandom);
      send_byte(d[k], ack, whole);
      chk(whole, "R5 data ack", whole, 1);
    end
    do_stop();
    hp();
    chk(wr_n == base + n, "R7 write count", wr_n - base, n);
    for (int k = 0; k < n; k++) begin
      chk(wr_a[(base + k) % 64] == cmd + 8'(k), "R7 write pointer", wr_a[(base + k) % 64], cmd + 8'(k));
      chk(wr_d[(base + k) % 64] == d[k], "R7 write data", wr_d[(base + k) % 64], d[k]);
    end
  endtask

  task automatic read_txn(input logic [6:0] a, input logic [7:0] cmd, input int n);
    logic ack, whole, rel;
    logic [7:0] d;
    do_start();
    send_byte({a, 1'b0}, ack, whole);
    send_byte(cmd, ack, whole);
    chk(ack, "R11 command before repeated start", ack, 1);
    do_start();
    send_byte({a, 1'b1}, ack, whole);
    chk(whole, "R11 address after repeated start", whole, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, d, rel);
      chk(d == rd_model(cmd + 8'(k)), "R8 read data", d, rd_model(cmd + 8'(k)));
      chk(rel, "R8 ninth clock released", rel, 1);
    end
    hp();
    chk(!sda_oe, "R8 read ends after nack", sda_oe, 0);
    do_stop();
  endtask

  task automatic expect_ignored(input logic [6:0] a, input string req);
    logic ack, whole;
    int base;
    base = wr_n;
    do_start();
    send_byte({a, 1'b0}, ack, whole);
    chk(!ack, {req, " address refused"}, ack, 0);
    send_byte(8'h10, ack, whole);
    send_byte(8'h33, ack, whole);
    chk(!ack, {req, " later byte ignored"}, ack, 0);
    do_stop(); hp();
    chk(wr_n == base, {req, " no write"}, wr_n - base, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, whole;
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!sda_oe && !rf_wr, "R1 reset outputs", {sda_oe, rf_wr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sda_oe && !rf_wr, "R1 idle outputs", {sda_oe, rf_wr}, 0);

    // R3 fallbacks for every strap code
    for (int s = 0; s < 4; s++) begin
      strap_sel = 2'(s);
      addr_reg = (s == 1) ? 7'h09 : (s == 2) ? 7'h7F : 7'h00;
      write_txn(BASE + 7'(s), 8'h20 + 8'(s), 1, "R3");
    end
    addr_reg = 7'h7F; strap_sel = 2'd2;
    expect_ignored(7'h7F, "R3 reserved code");

    // R2 register address and immediate change
    addr_reg = 7'h3A;
    write_txn(7'h3A, 8'h40, 2, "R2");
    expect_ignored(BASE + 7'd2, "R2 strap unused");
    addr_reg = 7'h21;
    expect_ignored(7'h3A, "R2 old address");
    write_txn(7'h21, 8'hFF, 2, "R2 new address");

    // R10 start and stop inside one clock-high interval
    m_sda = 1'b1; hp(); m_scl = 1'b1; hp();
    m_sda = 1'b0; hp(); m_sda = 1'b1; hp(); m_scl = 1'b0; hp();
    send_byte({7'h21, 1'b0}, ack, whole);
    chk(whole, "R10 address acked after illegal stop", whole, 1);
    do_stop();

    // R9 stop inside an address byte
    do_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    do_stop();
    m_scl = 1'b0; hp();
    send_byte({7'h21, 1'b0}, ack, whole);
    chk(!ack, "R9 no ack after mid-address stop", ack, 0);
    do_stop();

    // R9 stop inside a write data byte
    base = wr_n;
    do_start();
    send_byte({7'h21, 1'b0}, ack, whole);
    send_byte(8'h05, ack, whole);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    do_stop();
    m_scl = 1'b0; hp();
    send_byte(8'h77, ack, whole);
    chk(!ack, "R9 no ack after mid-data stop", ack, 0);
    do_stop(); hp();
    chk(wr_n == base, "R9 no write after stop", wr_n - base, 0);

    // R11 and R8 directed read with pointer wrap
    read_txn(7'h21, 8'hFE, 3);

    // R6 each refusal input
    for (int b = 0; b < 3; b++) begin
      reboot_busy = (b == 0); flash_busy = (b == 1); cmd_illegal = (b == 2);
      base = wr_n;
      do_start();
      send_byte({7'h21, 1'b0}, ack, whole);
      chk(whole, "R6 address still acked", whole, 1);
      send_byte(8'h12, ack, whole);
      chk(!ack, "R6 command refused", ack, 0);
      send_byte(8'h99, ack, whole);
      chk(!ack, "R6 later byte ignored", ack, 0);
      do_stop(); hp();
      chk(wr_n == base, "R6 no write", wr_n - base, 0);
    end
    reboot_busy = 1'b0; flash_busy = 1'b0; cmd_illegal = 1'b0;

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [6:0] ea;
      int kind, sel;
      sel = $urandom % 4;
      addr_reg = (sel == 0) ? 7'h00 : (sel == 1) ? 7'h09 : (sel == 2) ? 7'h7F : 7'(1 + $urandom % 126);
      strap_sel = 2'($urandom);
      ea = exp_addr(addr_reg, strap_sel);
      kind = $urandom % 4;
      case (kind)
        0: write_txn(ea, 8'($urandom), 1 + $urandom % 3, "R2 R3 random");
        1: read_txn(ea, 8'($urandom), 1 + $urandom % 3);
        2: expect_ignored(ea ^ 7'(1 + $urandom % 127), "R4");
        default: begin
          int b;
          b = $urandom % 3;
          reboot_busy = (b == 0); flash_busy = (b == 1); cmd_illegal = (b == 2);
          base = wr_n;
          do_start();
          send_byte({ea, 1'b0}, ack, whole);
          send_byte(8'($urandom), ack, whole);
          chk(!ack, "R6 random refusal", ack, 0);
          send_byte(8'h5C, ack, whole);
          do_stop(); hp();
          chk(wr_n == base, "R6 random no write", wr_n - base, 0);
          reboot_busy = 1'b0; flash_busy = 1'b0; cmd_illegal = 1'b0;
        end
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule